// File: doc/BRIEF.md
# Predicated Execution Flag Unit

This block holds the four status flags a small accumulator-style datapath derives from its ALU results and decides, for every issued instruction, whether that instruction may commit. Conditional behaviour comes from predication instead of branches. Each instruction brings a 4-bit condition mask. The instruction commits when at least one flag selected by the mask is set. A mask of all zeros means the instruction is unconditional.

Flag visibility is counted in issued instructions, not clock cycles. After an instruction writes the flags, the next issued instruction still tests the previous flag values. The instruction after that tests the new ones. Cycles in which no instruction is issued do not advance this slot. A committed instruction that has its flag-write enable set captures carry, sign, zero and parity-of-LSB from the ALU result. An instruction that is predicated off leaves the flags unchanged.

Top module: `flagpred_top`

## Requirements
- R1: After reset the flags tested by instructions are all zero, so any non-zero mask gives exec_en low until flags are written.
- R2: When instr_valid is high and cond_mask is 4'b0000, exec_en is high in that same cycle, whatever the flags hold.
- R3: When instr_valid is high and cond_mask is non-zero, exec_en is high exactly when (cond_mask & cur_flags) is non-zero. Several mask bits act as an OR of their flags.
- R4: Flag bit positions, shared by cond_mask and cur_flags: bit 3 is carry (alu_carry), bit 2 is negative (alu_result MSB), bit 1 is zero (alu_result equals 0) and bit 0 is odd (alu_result bit 0).
- R5: Flags written by one issued instruction are not seen by the next issued instruction. They become visible on cur_flags to the issued instruction after that.
- R6: An issued instruction with flag_we low does not change the flags.
- R7: An issued instruction whose exec_en is low does not change the flags, even when flag_we is high.
- R8: With instr_valid low, exec_en is low, and the cycle neither advances the delay slot nor updates the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| instr_valid | input | 1 | An instruction is issued this cycle |
| cond_mask | input | 4 | Condition mask of the issued instruction (bit order as in R4) |
| alu_result | input | DATA_W | ALU result of the issued instruction |
| alu_carry | input | 1 | ALU carry-out of the issued instruction |
| flag_we | input | 1 | The issued instruction updates the flags if it commits |
| exec_en | output | 1 | The issued instruction commits |
| cur_flags | output | 4 | Flags that the current instruction is tested against |

## Verification
Single-bit masks are applied against single-flag states. These separate a swapped or mis-positioned flag bit from a correct one. Multi-bit masks with exactly one matching flag, and with no matching flag, separate an OR combination from an AND or from an equality test. Back-to-back flag writes, writes separated by non-writing instructions, and writes separated by idle cycles show whether visibility follows issued instructions with exactly one slot of delay. Predicated-off writes and writes with flag_we low then show that the flags stay unchanged. A long run of mixed random instructions is also compared cycle by cycle against a behavioural model.

// File: rtl/flagpred_pkg.sv
package flagpred_pkg;
  localparam int NFLAG     = 4;
  localparam int FLG_ODD   = 0;
  localparam int FLG_ZERO  = 1;
  localparam int FLG_NEG   = 2;
  localparam int FLG_CARRY = 3;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/flagpred_rst_sync.sv
module flagpred_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flagpred_calc.sv
module flagpred_calc
  import flagpred_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  output flag_vec_t         flags
);
  always_comb begin
    flags            = '0;
    flags[FLG_CARRY] = carry;
    flags[FLG_NEG]   = result[DATA_W-1];
    flags[FLG_ZERO]  = (result == '0);
    flags[FLG_ODD]   = result[0];
  end
endmodule

// File: rtl/flagpred_cond.sv
module flagpred_cond
  import flagpred_pkg::*;
(
  input  logic      valid,
  input  flag_vec_t mask,
  input  flag_vec_t flags,
  output logic      exec
);
  logic [NFLAG-1:0] hit;

  for (genvar i = 0; i < NFLAG; i++) begin : g_hit
    assign hit[i] = mask[i] & flags[i];
  end

  always_comb begin
    exec = valid & ((mask == '0) | (|hit));
  end
endmodule

// File: rtl/flagpred_pipe.sv
module flagpred_pipe
  import flagpred_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      wr,
  input  flag_vec_t new_flags,
  output flag_vec_t vis_flags
);
  flag_vec_t pend_q, pend_d;
  flag_vec_t vis_q,  vis_d;

  always_comb begin
    pend_d = pend_q;
    vis_d  = vis_q;
    if (adv) begin
      vis_d = pend_q;
      if (wr) pend_d = new_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      vis_q  <= '0;
    end else begin
      pend_q <= pend_d;
      vis_q  <= vis_d;
    end
  end

  assign vis_flags = vis_q;

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(vis_q) && $stable(pend_q)));

  // R5
  slot_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (vis_q == $past(pend_q)));

  // R6
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pend_q));
endmodule

// File: rtl/flagpred_top.sv
module flagpred_top
  import flagpred_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        cond_mask,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              flag_we,
  output logic              exec_en,
  output logic [3:0]        cur_flags
);
  logic      rst_sync_n;
  flag_vec_t calc_flags;
  flag_vec_t vis_flags;
  logic      commit_wr;

  flagpred_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flagpred_calc #(.DATA_W(DATA_W)) u_calc (
    .result (alu_result),
    .carry  (alu_carry),
    .flags  (calc_flags)
  );

  flagpred_cond u_cond (
    .valid (instr_valid),
    .mask  (cond_mask),
    .flags (vis_flags),
    .exec  (exec_en)
  );

  assign commit_wr = exec_en & flag_we;

  flagpred_pipe u_pipe (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .adv       (instr_valid),
    .wr        (commit_wr),
    .new_flags (calc_flags),
    .vis_flags (vis_flags)
  );

  assign cur_flags = vis_flags;

  // R2
  uncond_exec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && cond_mask == 4'b0000) |-> exec_en);

  // R3
  masked_exec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && cond_mask != 4'b0000) |-> ((cond_mask & cur_flags) != 4'b0000));

  // R7
  predoff_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && !exec_en) ##1 (instr_valid) |=> $stable(cur_flags));

  // R8
  idle_exec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |-> !exec_en);
endmodule

// File: tb/sim_flagpred_top.sv
`timescale 1ns/1ps
module sim_flagpred_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_valid;
  logic [3:0] cond_mask;
  logic [7:0] alu_result;
  logic       alu_carry;
  logic       flag_we;
  logic       exec_en;
  logic [3:0] cur_flags;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  int m_vis  = 0;
  int m_pend = 0;

  always #2 clk = ~clk;

  flagpred_top #(.DATA_W(8)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .cond_mask   (cond_mask),
    .alu_result  (alu_result),
    .alu_carry   (alu_carry),
    .flag_we     (flag_we),
    .exec_en     (exec_en),
    .cur_flags   (cur_flags)
  );

  function automatic int flags_of(int res, int cy);
    return (cy << 3) | (((res >> 7) & 1) << 2) | ((res == 0) ? 2 : 0) | (res & 1);
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit v, int mask, int res, bit cy, bit we);
    int exp_exec;
    @(negedge clk);
    instr_valid = v;
    cond_mask   = mask[3:0];
    alu_result  = res[7:0];
    alu_carry   = cy;
    flag_we     = we;
    #1;
    exp_exec = v && ((mask == 0) || ((mask & m_vis) != 0));
    chk(req, int'(exec_en), exp_exec, "exec_en");
    chk(req, int'(cur_flags), m_vis, "cur_flags");
    if (v) begin
      int nv;
      nv = m_pend;
      if (exp_exec && we) m_pend = flags_of(res, cy);
      m_vis = nv;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; instr_valid = 0; cond_mask = 0; alu_result = 0;
    alu_carry = 0; flag_we = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset flags zero; every non-zero mask is blocked
    step("R1", 1, 4'hF, 0, 0, 0);
    step("R1", 1, 4'h1, 0, 0, 0);
    // R2: unconditional instruction writes zero flag (res 0)
    step("R2", 1, 4'h0, 0, 0, 1);
    // R5: next instruction still sees old flags (zero clear)
    step("R5", 1, 4'h2, 8'h55, 1, 0);
    // R5: second one sees zero flag
    step("R5", 1, 4'h2, 8'h55, 1, 0);
    // R4: write negative only (0x80, carry 0)
    step("R4", 1, 4'h0, 8'h80, 0, 1);
    step("R4", 1, 4'h0, 0, 0, 0);
    step("R4", 1, 4'h4, 0, 0, 0);
    // R3: OR of carry|odd misses, neg|zero hits
    step("R3", 1, 4'h9, 0, 0, 0);
    step("R3", 1, 4'h6, 0, 0, 0);
    // R4: carry and odd (0x03, carry 1)
    step("R4", 1, 4'h0, 8'h03, 1, 1);
    step("R4", 1, 4'h0, 0, 0, 0);
    step("R4", 1, 4'h8, 0, 0, 0);
    step("R4", 1, 4'h1, 0, 0, 0);
    step("R3", 1, 4'h6, 0, 0, 0);
    // R7: predicated-off write (mask zero-flag, not set)
    step("R7", 1, 4'h2, 8'h00, 0, 1);
    step("R7", 1, 4'h0, 0, 0, 0);
    step("R7", 1, 4'h0, 0, 0, 0);
    // R6: committed but flag_we low
    step("R6", 1, 4'h0, 8'h80, 0, 0);
    step("R6", 1, 4'h0, 0, 0, 0);
    step("R6", 1, 4'h0, 0, 0, 0);
    // R5: back-to-back writes
    step("R5", 1, 4'h0, 8'h00, 0, 1);
    step("R5", 1, 4'h0, 8'h80, 0, 1);
    step("R5", 1, 4'h2, 0, 0, 0);
    step("R5", 1, 4'h4, 0, 0, 0);
    // R8: idle cycles do not advance the slot
    step("R8", 1, 4'h0, 8'h01, 0, 1);
    step("R8", 0, 4'h0, 8'h00, 1, 1);
    step("R8", 0, 4'h1, 8'h00, 1, 1);
    step("R8", 0, 4'h0, 8'h00, 1, 1);
    step("R8", 1, 4'h1, 0, 0, 0);
    step("R8", 1, 4'h1, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom);
      step("R3", (r % 5) != 0, (r >> 4) & 15, (r >> 8) & 255, r[16], r[17]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule